// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block turns a fast module clock into the serial clock of a SPI shift engine. A 13-bit clock-control word picks one of two division laws. The linear law divides by 2·(n+1), where n is an 8-bit coefficient. The exponential law divides by 2^(n+1), where n is a 4-bit exponent. Both laws give a serial clock with a 50% duty cycle, because the block counts half-periods and toggles the clock at each half-period boundary.

While `run_i` is low, the divider is parked: its counter is held at zero and the serial clock rests at the idle level given by `cpol_i`. While `run_i` is high, the serial clock toggles. Each toggle comes with a one-cycle strobe that says whether the edge leaves the idle level (leading) or returns to it (trailing). The shifter picks its sample and shift edges from these two strobes according to its clock phase setting. A new control word is taken up only while idle or at a half-period boundary, so a reprogrammed divider never produces a shortened half-period.

Top module: `sck_divgen`

## Requirements
- R1: With `ctrl_word_i[12]`=1 (linear law), n=`ctrl_word_i[7:0]`, and every half-period of `sck_o` lasts n+1 module-clock cycles, so the full period is 2·(n+1) cycles at 50% duty. Bits 11:8 are ignored.
- R2: With `ctrl_word_i[12]`=0 (exponential law), n=`ctrl_word_i[11:8]`, and every half-period lasts 2^n cycles, so the full period is 2^(n+1) cycles. Bits 7:0 are ignored.
- R3: In any cycle where `run_i` is sampled low, the next clock edge sets `sck_o` to the sampled `cpol_i`, clears both strobes and puts the half-period count back to zero.
- R4: When `run_i` is first sampled high at edge k, after an idle cycle, the first toggle of `sck_o` happens at edge k+H-1, where H is the half-period length of the control word sampled at edge k-1. An interruption of `run_i` lasting one cycle restarts this count.
- R5: A control word change while running does not alter the half-period in progress. The word sampled at the edge that ends a half-period sets the length of the next one.
- R6: `lead_o` is high for exactly the one cycle in which `sck_o` has just left the `cpol_i` level. `trail_o` is high for exactly the one cycle in which `sck_o` has just returned to it. The two strobes are never high together.
- R7: The idle level follows `cpol_i`. With `cpol_i`=1 the leading edge is a falling edge of `sck_o`.
- R8: During reset (`rst_ni` low), `sck_o`, `lead_o` and `trail_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High to generate the serial clock, low to park it |
| cpol_i | input | 1 | Idle level of the serial clock |
| ctrl_word_i | input | 13 | Clock control: [7:0] linear coefficient, [11:8] exponent, [12] law select (1 = linear) |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on an edge leaving the idle level |
| trail_o | output | 1 | One-cycle strobe on an edge returning to the idle level |

## Verification
A wrong half-period count or a wrongly latched coefficient moves the next `sck_o` toggle and its strobe. This shows at the ports within one half-period, and at once for the short laws. A polarity or strobe-classification error shows on the first toggle after the run starts, or in the first idle cycle. The reference model recomputes the expected `sck_o`, `lead_o` and `trail_o` on every clock edge, so the first cycle of divergence is reported. Mid-run coefficient changes and a one-cycle run drop check the update timing and the restart timing exactly.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  localparam int LIN_W  = 8;
  localparam int EXP_W  = 4;
  localparam int CTRL_W = LIN_W + EXP_W + 1;
  localparam int EXP_SPAN = 1 << EXP_W;
  // half-period terminal count must hold 2^(2^EXP_W - 1) - 1 and 2^LIN_W - 1
  localparam int CNT_W  = (LIN_W > EXP_SPAN) ? LIN_W : EXP_SPAN;

  typedef struct packed {
    logic             lin_sel;
    logic [EXP_W-1:0] exp_n;
    logic [LIN_W-1:0] lin_n;
  } div_cfg_t;
endpackage

// File: rtl/sckdiv_term_calc.sv
module sckdiv_term_calc
  import sckdiv_pkg::*;
(
  input  div_cfg_t         cfg_i,
  output logic [CNT_W-1:0] term_o
);
  logic [CNT_W-1:0] exp_mask;

  // 2^n - 1 as a thermometer mask of n ones
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign exp_mask[i] = (32'(cfg_i.exp_n) > 32'(i));
  end

  assign term_o = cfg_i.lin_sel ? CNT_W'(cfg_i.lin_n) : exp_mask;
endmodule

// File: rtl/sckdiv_half_cnt.sv
module sckdiv_half_cnt
  import sckdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_i);

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/sckdiv_edge_gen.sv
module sckdiv_edge_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cpol_i,
  input  logic tick_i,
  output logic sck_o,
  output logic lead_o,
  output logic trail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_o   <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!run_i) begin
      sck_o   <= cpol_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= tick_i && (sck_o == cpol_i);
      trail_o <= tick_i && (sck_o != cpol_i);
      if (tick_i) sck_o <= ~sck_o;
    end
  end

  assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sck_o == $past(cpol_i)) && !lead_o && !trail_o);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  assert_lead_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |-> sck_o != $past(sck_o));
endmodule

// File: rtl/sck_divgen.sv
module sck_divgen
  import sckdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  output logic              sck_o,
  output logic              lead_o,
  output logic              trail_o
);
  div_cfg_t         cfg_q;
  logic [CNT_W-1:0] term;
  logic             tick;

  // new coefficients only between half-periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cfg_q <= '0;
    else if (!run_i || tick)  cfg_q <= div_cfg_t'(ctrl_word_i);
  end

  sckdiv_term_calc u_term (
    .cfg_i  (cfg_q),
    .term_o (term)
  );

  sckdiv_half_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .term_i (term),
    .tick_o (tick)
  );

  sckdiv_edge_gen u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .cpol_i  (cpol_i),
    .tick_i  (tick),
    .sck_o   (sck_o),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );

  assert_cfg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick) |=> $stable(cfg_q));
endmodule

// File: tb/tb_sck_divgen.sv
`timescale 1ns/1ps
module tb_sck_divgen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic        cpol;
  logic [12:0] ctrl;
  logic        sck, lead, trail;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_req = "R8";

  // reference model state
  int    m_cnt;
  int    m_half;
  bit    m_sck, m_lead, m_trail;

  always #2.5 clk = ~clk;

  sck_divgen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .run_i       (run),
    .cpol_i      (cpol),
    .ctrl_word_i (ctrl),
    .sck_o       (sck),
    .lead_o      (lead),
    .trail_o     (trail)
  );

  function automatic int half_of(logic [12:0] w);
    if (w[12]) return int'(w[7:0]) + 1;
    return 1 << w[11:8];
  endfunction

  function automatic logic [12:0] mk(bit lin, int e, int l);
    return {lin, 4'(e), 8'(l)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_half = 1; m_sck = 0; m_lead = 0; m_trail = 0;
    end else if (!run) begin
      m_cnt = 0; m_sck = cpol; m_lead = 0; m_trail = 0;
      m_half = half_of(ctrl);
    end else begin
      m_cnt++;
      m_lead = 0; m_trail = 0;
      if (m_cnt == m_half) begin
        m_cnt = 0;
        if (m_sck == cpol) m_lead = 1; else m_trail = 1;
        m_sck = ~m_sck;
        m_half = half_of(ctrl);
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (sck !== m_sck || lead !== m_lead || trail !== m_trail) begin
        failures++;
        $display("FAIL %s t=%0t actual sck/lead/trail=%b%b%b expected=%b%b%b",
                 cur_req, $time, sck, lead, trail, m_sck, m_lead, m_trail);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; cpol = 1'b0; ctrl = '0;
    cur_req = "R8"; cyc(3);                          // reset outputs all zero
    rst_n = 1'b1;

    cur_req = "R7"; cpol = 1'b1; ctrl = mk(1, 0, 2); cyc(5);
    cur_req = "R3"; cpol = 1'b0; cyc(5);

    cur_req = "R1"; ctrl = mk(1, 9, 0);   run = 1'b1; cyc(20);
    run = 1'b0; cyc(2);
    ctrl = mk(1, 15, 3);  run = 1'b1; cyc(40);
    run = 1'b0; cyc(2);
    ctrl = mk(1, 0, 255); run = 1'b1; cyc(1100);
    run = 1'b0; cyc(2);

    cur_req = "R2"; ctrl = mk(0, 0, 8'hAB); run = 1'b1; cyc(20);
    run = 1'b0; cyc(2);
    ctrl = mk(0, 2, 8'h55); run = 1'b1; cyc(40);
    run = 1'b0; cyc(2);
    ctrl = mk(0, 9, 0);     run = 1'b1; cyc(2100);
    run = 1'b0; cyc(2);

    cur_req = "R6"; cpol = 1'b1; cyc(2);
    ctrl = mk(1, 0, 1); run = 1'b1; cyc(30);
    run = 1'b0; cyc(2); cpol = 1'b0; cyc(2);

    cur_req = "R5"; ctrl = mk(1, 0, 5); run = 1'b1; cyc(4);
    ctrl = mk(1, 0, 1); cyc(30);
    ctrl = mk(0, 3, 0); cyc(3);
    ctrl = mk(1, 0, 6); cyc(50);

    cur_req = "R4"; ctrl = mk(1, 0, 3); cyc(5);
    run = 1'b0; cyc(1);
    run = 1'b1; cyc(25);
    run = 1'b0; cyc(3);

    cur_req = "R2"; ctrl = mk(0, 15, 0); run = 1'b1; cyc(70000);
    run = 1'b0; cyc(3);

    finish_run();
  end
endmodule